// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Contention Arbiter

A 1024-word by 8-bit memory reachable from two independent ports, left and right. Each port has its own active-low select, a read/write strobe (low means write), an active-low output enable, a 10-bit address, write data, read data and a read-valid flag. The two ports work independently until both are selected on the same address. At that point an arbiter gives the location to one port and pulls the other port's active-low busy flag down.

The model is synchronous to one clock and turns the asynchronous arbitration order into clock-edge order. If the addresses already matched when the selects came low, the port selected on an earlier edge wins. If both ports were already selected when their addresses came to match, the port whose address did not move on the matching edge wins. A tie on the same edge goes to the left port. The grant is kept in a registered owner state until the clash ends. The losing port's writes are dropped and its reads are marked invalid. Once the winner deselects or moves its address, the loser's busy rises in that same cycle. An access the loser is still holding then completes on that edge.

Top module: `dpram_arbiter`

## Requirements
- R1: When the two ports are not both selected, or their addresses differ, both busy flags stay high and each port reads and writes on its own.
- R2: When the addresses match and one port's select was already low on the previous edge while the other's was not, the earlier-selected port wins. If neither was selected on the previous edge, the left port wins.
- R3: When both ports were selected on the previous edge and their addresses come to match, the port whose address did not change on this edge wins. If both addresses changed, the left port wins.
- R4: Only the losing port has busy low, and busy falls in the same cycle the clash appears. A write from a port whose busy is low does not change memory. A read on it gives read-valid low on the next cycle.
- R5: A write from the winning port during a clash is stored.
- R6: While the clash persists, the grant stays with the first winner, even when the inputs would now favour the other port.
- R7: In the first cycle after the winner deselects or changes address, the loser's busy is high. A write it is still holding is stored at that edge.
- R8: A read is a selected port with read/write high and output enable low. Its data appears with read-valid high one cycle later. In every other case read-valid is low and read data is 0 in the next cycle.
- R9: After reset, read-valid and read data are 0 on both ports, no grant is held, and both busy flags are high while the ports are deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Left select, active low |
| l_rw_n | input | 1 | Left read/write, low writes |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left lost arbitration, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_rw_n | input | 1 | Right read/write, low writes |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right lost arbitration, active low |

## Verification
The properties assume that port inputs change only between clock edges, and that both selects are high while reset is asserted. Without that, the first post-reset grant would depend on history the model never saw. The stimulus drives every input just after the falling edge, holds the selects high through reset, and writes each location before any read of it checks the data. The arbitration scenarios run as one table that steps cycle by cycle through select-first, address-first, tie and grant-hold cases. Directed sequences then cover dropped writes, winner writes and release.

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs_n,
  input  logic          l_rw_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  output logic          l_busy_n,
  input  logic          r_cs_n,
  input  logic          r_rw_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid,
  output logic          r_busy_n
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {OWN_NONE, OWN_L, OWN_R} owner_t;

  logic [DW-1:0] mem [DEPTH];
  owner_t owner, pick, eff;
  logic l_sel_q, r_sel_q, conf_q;
  logic [AW-1:0] l_addr_q, r_addr_q;

  wire l_sel    = ~l_cs_n;
  wire r_sel    = ~r_cs_n;
  wire conflict = l_sel & r_sel & (l_addr == r_addr);

  always_comb begin
    pick = OWN_L;
    if (l_sel_q && !r_sel_q)      pick = OWN_L;
    else if (r_sel_q && !l_sel_q) pick = OWN_R;
    else if (l_sel_q && r_sel_q) begin
      if (l_addr != l_addr_q && r_addr == r_addr_q) pick = OWN_R;
      else                                          pick = OWN_L;
    end
  end

  assign eff      = (owner == OWN_NONE) ? pick : owner;
  assign l_busy_n = ~(conflict & (eff == OWN_R));
  assign r_busy_n = ~(conflict & (eff == OWN_L));

  wire l_we = l_sel & ~l_rw_n & l_busy_n;
  wire r_we = r_sel & ~r_rw_n & r_busy_n;
  wire l_re = l_sel & l_rw_n & ~l_oe_n & l_busy_n;
  wire r_re = r_sel & r_rw_n & ~r_oe_n & r_busy_n;

  always_ff @(posedge clk) begin
    if (l_we) mem[l_addr] <= l_wdata;
    if (r_we) mem[r_addr] <= r_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner    <= OWN_NONE;
      conf_q   <= 1'b0;
      l_sel_q  <= 1'b0;
      r_sel_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      l_rdata  <= '0;
      r_rdata  <= '0;
      l_rvalid <= 1'b0;
      r_rvalid <= 1'b0;
    end else begin
      owner    <= conflict ? eff : OWN_NONE;
      conf_q   <= conflict;
      l_sel_q  <= l_sel;
      r_sel_q  <= r_sel;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      l_rdata  <= l_re ? mem[l_addr] : '0;
      r_rdata  <= r_re ? mem[r_addr] : '0;
      l_rvalid <= l_re;
      r_rvalid <= r_re;
    end
  end

  // R1
  no_false_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs_n || r_cs_n || l_addr != r_addr) |-> (l_busy_n && r_busy_n));

  // R4
  single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_q && conflict) |-> ($stable(l_busy_n) && $stable(r_busy_n)));

  // R4
  l_loser_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |=> !l_rvalid);

  // R4
  r_loser_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |=> !r_rvalid);

  // R8
  l_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs_n || l_oe_n || !l_rw_n) |=> (!l_rvalid && l_rdata == '0));

  // R8
  r_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_cs_n || r_oe_n || !r_rw_n) |=> (!r_rvalid && r_rdata == '0));
endmodule

// File: tb/dpram_arbiter_tb.sv
module dpram_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] A = 10'h155, B = 10'h0AA, C = 10'h3FF;

  typedef struct packed {
    logic       lcs;
    logic [9:0] la;
    logic       rcs;
    logic [9:0] ra;
    logic       elb;
    logic       erb;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A, 1'b1, B, 1'b1, 1'b1},  // R1 only left selected
    '{1'b0, A, 1'b0, B, 1'b1, 1'b1},  // R1 different addresses
    '{1'b0, A, 1'b0, A, 1'b1, 1'b0},  // R3 right moved, left wins
    '{1'b0, A, 1'b0, A, 1'b1, 1'b0},  // R6 hold
    '{1'b0, B, 1'b0, A, 1'b1, 1'b1},  // R7 clash over
    '{1'b0, B, 1'b0, B, 1'b1, 1'b0},  // R3 right moved, left wins
    '{1'b0, A, 1'b0, B, 1'b1, 1'b1},  // R1
    '{1'b0, B, 1'b0, B, 1'b0, 1'b1},  // R3 left moved, right wins
    '{1'b0, B, 1'b0, B, 1'b0, 1'b1},  // R6 both stable, right keeps grant
    '{1'b1, B, 1'b1, B, 1'b1, 1'b1},  // R1 idle
    '{1'b0, A, 1'b0, A, 1'b1, 1'b0},  // R2 selected on same edge, left
    '{1'b1, A, 1'b1, A, 1'b1, 1'b1},
    '{1'b0, A, 1'b1, A, 1'b1, 1'b1},
    '{1'b0, A, 1'b0, A, 1'b1, 1'b0},  // R2 left selected first
    '{1'b1, A, 1'b1, A, 1'b1, 1'b1},
    '{1'b1, A, 1'b0, A, 1'b1, 1'b1},
    '{1'b0, A, 1'b0, A, 1'b0, 1'b1},  // R2 right selected first
    '{1'b1, A, 1'b1, A, 1'b1, 1'b1},
    '{1'b0, A, 1'b0, B, 1'b1, 1'b1},
    '{1'b0, C, 1'b0, C, 1'b1, 1'b0},  // R3 both moved, left
    '{1'b1, C, 1'b1, C, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_cs_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
  logic r_cs_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_busy_n, r_busy_n;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_n(l_busy_n),
    .r_cs_n(r_cs_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_n(r_busy_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic lcs, input logic lrw, input logic loe, input logic [9:0] la,
                       input logic [7:0] ld, input logic rcs, input logic rrw, input logic roe,
                       input logic [9:0] ra, input logic [7:0] rd);
    @(negedge clk);
    l_cs_n = lcs; l_rw_n = lrw; l_oe_n = loe; l_addr = la; l_wdata = ld;
    r_cs_n = rcs; r_rw_n = rrw; r_oe_n = roe; r_addr = ra; r_wdata = rd;
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 state under reset
    check("R9 l_rvalid", {7'd0, l_rvalid}, 8'd0);
    check("R9 r_rvalid", {7'd0, r_rvalid}, 8'd0);
    check("R9 l_rdata", l_rdata, 8'd0);
    check("R9 busy flags", {6'd0, l_busy_n, r_busy_n}, 8'd3);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].lcs, 1'b1, 1'b1, VEC[i].la, 8'h00, VEC[i].rcs, 1'b1, 1'b1, VEC[i].ra, 8'h00);
      check($sformatf("R1/R2/R3/R6 table row %0d busy", i),
            {6'd0, l_busy_n, r_busy_n}, {6'd0, VEC[i].elb, VEC[i].erb});
    end

    // R1 independent writes on different addresses
    drive(1'b0, 1'b0, 1'b1, A, 8'h11, 1'b0, 1'b0, 1'b1, B, 8'h22);
    check("R1 busy during independent writes", {6'd0, l_busy_n, r_busy_n}, 8'd3);
    drive(1'b0, 1'b1, 1'b0, B, 8'h00, 1'b0, 1'b1, 1'b0, A, 8'h00);
    @(negedge clk);
    check("R8 left reads right's write", l_rdata, 8'h22);
    check("R8 left rvalid", {7'd0, l_rvalid}, 8'd1);
    check("R8 right reads left's write", r_rdata, 8'h11);
    // R8 output enable high gives no data
    l_cs_n = 1'b0; l_rw_n = 1'b1; l_oe_n = 1'b1; l_addr = A; r_cs_n = 1'b1; #1;
    @(negedge clk);
    check("R8 oe high rvalid", {7'd0, l_rvalid}, 8'd0);
    check("R8 oe high rdata", l_rdata, 8'd0);
    // R2 left selected earlier, right writes same address and loses
    r_cs_n = 1'b0; r_rw_n = 1'b0; r_oe_n = 1'b1; r_addr = A; r_wdata = 8'h44; #1;
    check("R4 right busy on clash", {6'd0, l_busy_n, r_busy_n}, 8'd2);
    // R5 winner writes while loser holds its write
    drive(1'b0, 1'b0, 1'b1, A, 8'h55, 1'b0, 1'b0, 1'b1, A, 8'h44);
    check("R6 right still busy", {7'd0, r_busy_n}, 8'd0);
    drive(1'b0, 1'b1, 1'b0, A, 8'h00, 1'b0, 1'b0, 1'b1, A, 8'h44);
    @(negedge clk);
    check("R4/R5 left sees winner data, loser write dropped", l_rdata, 8'h55);
    // R7 winner leaves, loser write completes
    l_cs_n = 1'b1; #1;
    check("R7 right busy released", {6'd0, l_busy_n, r_busy_n}, 8'd3);
    drive(1'b1, 1'b1, 1'b1, A, 8'h00, 1'b0, 1'b1, 1'b0, A, 8'h00);
    @(negedge clk);
    check("R7 held write stored", r_rdata, 8'h44);
    // R2 right selected first, left read loses
    l_cs_n = 1'b0; l_rw_n = 1'b1; l_oe_n = 1'b0; l_addr = A; #1;
    check("R2 left busy", {6'd0, l_busy_n, r_busy_n}, 8'd1);
    @(negedge clk);
    check("R4 loser read invalid", {7'd0, l_rvalid}, 8'd0);
    check("R8 winner read data", r_rdata, 8'h44);
    drive(1'b1, 1'b1, 1'b1, A, 8'h00, 1'b1, 1'b1, 1'b1, A, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule